// File: doc/BRIEF.md
# Four-Lane PCS Receive Control Decoder

This block is the control state machine on the receive side of a four-lane 10 Gb/s Ethernet physical coding sublayer. Every clock it accepts one column of four characters, already deskewed and 8b/10b-decoded. Each lane carries an 8-bit value, a flag that marks it as a control character, and a flag that marks a code violation. The block produces a 32-bit data word and a 4-bit control word of the kind a 10 Gb/s media-independent interface carries. Lane 0 sits in bits 7:0, and control bit n belongs to lane n.

The block follows the link between frames, at frame start, inside a frame and during sequence ordered sets. It turns idle columns into the standard idle pattern and passes sequence columns through. It checks every terminate column against the column that follows it, and it marks errors with error control codes.

The output lags the input by two clocks. This gives one column of lookahead for the end-of-frame check. An error character inside a frame does not end the frame, so a later terminate column is still checked and converted.

Top module: `pcs_rx_decode`

Input character codes (control flag set): K = 0xBC, A = 0x7C, R = 0x1C, start = 0xFB, terminate = 0xFD, error = 0xFE, sequence = 0x9C. Output control codes (control bit set): idle 0x07, start 0xFB, terminate 0xFD, error 0xFE, sequence 0x9C. A lane is "bad" when its control flag or its violation flag is set.

## Requirements
- R1: Outside a frame, a column whose four lanes are all control K, A or R with no violation is output as 0x07 in every lane with control 0b1111.
- R2: A start column has control 0xFB in lane 0, non-control lanes 1 to 3 and no violation. Outside a frame it is output unchanged and opens a frame. Inside a frame its lane 0 becomes an error code.
- R3: Outside a frame, a sequence column is output unchanged with control 0b0001. A sequence column has control 0x9C in lane 0, non-control lanes 1 to 3 and no violation.
- R4: A terminate column is checked and converted in any state. Its terminate lane is the lowest lane holding control 0xFD with no violation. When every later lane is control K and the next input column is all idle, the output carries 0xFD in the terminate lane, 0x07 with control in later lanes, and the earlier lanes by the in-frame rule. The block then leaves the frame.
- R5: A terminate column that fails the end check is output as 0xFE with control in all four lanes, and the block leaves the frame.
- R6: Inside a frame, every bad lane of a non-terminate column becomes 0xFE with control set, every other lane is passed as data with control clear, and the frame continues.
- R7: Outside a frame, a column that directly follows a sequence column and is neither idle, sequence, start nor terminate is output as 0xFE with control in all lanes.
- R8: Outside a frame, any other column is passed through with its control flags. Lanes with a violation or a control 0xFE become 0xFE with control set.
- R9: Each column appears at the output two clocks after it is presented.
- R10: While reset is asserted, and after it is released, the output is an idle column and the block is outside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Column clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 32 | Decoded characters, lane 0 in bits 7:0 |
| rx_ctrl_i | input | 4 | Per-lane control-character flag |
| rx_cv_i | input | 4 | Per-lane code-violation flag |
| xg_data_o | output | 32 | Output data word |
| xg_ctrl_o | output | 4 | Output control word |

## Verification
The bench places the terminate character in each of the four lanes and follows it with a clean idle column, a non-idle column, or a non-K lane after the terminate. A design that checked the wrong lanes, or ignored the lookahead column, would pass a bad ending or reject a good one. Error characters and violations are injected in mid-frame ahead of a clean terminate. A design that fell out of frame on an error would then let the terminate escape unconverted or leave later data unmarked. Sequence columns are followed by idle, by further sequence columns and by garbage. A start column is sent inside a frame, where a design that restarted instead of flagging it would be caught.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam logic [7:0] K_K     = 8'hBC;
  localparam logic [7:0] K_A     = 8'h7C;
  localparam logic [7:0] K_R     = 8'h1C;
  localparam logic [7:0] C_IDLE  = 8'h07;
  localparam logic [7:0] C_START = 8'hFB;
  localparam logic [7:0] C_TERM  = 8'hFD;
  localparam logic [7:0] C_ERR   = 8'hFE;
  localparam logic [7:0] C_SEQ   = 8'h9C;

  typedef enum logic [1:0] {
    ST_RECV = 2'd0,
    ST_SEQ  = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/pcs_rx_col_class.sv
module pcs_rx_col_class
  import pcs_rx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 8,
  parameter int PW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*CW-1:0] d_i,
  input  logic [LANES-1:0]    c_i,
  input  logic [LANES-1:0]    v_i,
  output logic                idle_o,
  output logic                seq_o,
  output logic                start_o,
  output logic                term_o,
  output logic [PW-1:0]       term_pos_o,
  output logic [LANES-1:0]    k_tail_o,
  output logic [LANES-1:0]    bad_o,
  output logic [LANES-1:0]    err_o
);
  logic [LANES-1:0] lane_idle, lane_k, lane_term;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic [CW-1:0] ch;
    assign ch            = d_i[gl*CW +: CW];
    assign lane_idle[gl] = c_i[gl] & ~v_i[gl] & (ch == K_K || ch == K_A || ch == K_R);
    assign lane_k[gl]    = c_i[gl] & ~v_i[gl] & (ch == K_K);
    assign lane_term[gl] = c_i[gl] & ~v_i[gl] & (ch == C_TERM);
    assign bad_o[gl]     = c_i[gl] | v_i[gl];
    assign err_o[gl]     = v_i[gl] | (c_i[gl] & (ch == C_ERR));
  end

  // lowest terminate lane wins
  always_comb begin
    term_pos_o = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (lane_term[l]) term_pos_o = PW'(l);
  end

  // k_tail_o[p]: every lane above p is a clean K
  always_comb begin
    for (int p = 0; p < LANES; p++) begin
      k_tail_o[p] = 1'b1;
      for (int l = 0; l < LANES; l++)
        if (l > p && !lane_k[l]) k_tail_o[p] = 1'b0;
    end
  end

  assign idle_o  = &lane_idle;
  assign term_o  = |lane_term;
  assign seq_o   = c_i[0] & ~v_i[0] & (d_i[CW-1:0] == C_SEQ)   & ~|bad_o[LANES-1:1];
  assign start_o = c_i[0] & ~v_i[0] & (d_i[CW-1:0] == C_START) & ~|bad_o[LANES-1:1];
endmodule

// File: rtl/pcs_rx_term_xlate.sv
module pcs_rx_term_xlate
  import pcs_rx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 8,
  parameter int PW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*CW-1:0] d_i,
  input  logic [LANES-1:0]    bad_i,
  input  logic [PW-1:0]       pos_i,
  input  logic                pass_i,
  output logic [LANES*CW-1:0] d_o,
  output logic [LANES-1:0]    c_o
);
  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    localparam logic [PW-1:0] LIDX = PW'(gl);
    always_comb begin
      if (!pass_i) begin
        d_o[gl*CW +: CW] = C_ERR;
        c_o[gl]          = 1'b1;
      end else if (LIDX < pos_i) begin
        d_o[gl*CW +: CW] = bad_i[gl] ? C_ERR : d_i[gl*CW +: CW];
        c_o[gl]          = bad_i[gl];
      end else if (LIDX == pos_i) begin
        d_o[gl*CW +: CW] = C_TERM;
        c_o[gl]          = 1'b1;
      end else begin
        d_o[gl*CW +: CW] = C_IDLE;
        c_o[gl]          = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcs_rx_decode.sv
module pcs_rx_decode
  import pcs_rx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CW    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*CW-1:0] rx_data_i,
  input  logic [LANES-1:0]    rx_ctrl_i,
  input  logic [LANES-1:0]    rx_cv_i,
  output logic [LANES*CW-1:0] xg_data_o,
  output logic [LANES-1:0]    xg_ctrl_o
);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANES*CW-1:0] IDLE_COL = {LANES{C_IDLE}};
  localparam logic [LANES*CW-1:0] ERR_COL  = {LANES{C_ERR}};

  // classification of the incoming (lookahead) column
  logic             in_idle, in_seq, in_start, in_term;
  logic [PW-1:0]    in_pos;
  logic [LANES-1:0] in_ktail, in_bad, in_err;

  pcs_rx_col_class #(.LANES(LANES), .CW(CW), .PW(PW)) u_class (
    .d_i(rx_data_i), .c_i(rx_ctrl_i), .v_i(rx_cv_i),
    .idle_o(in_idle), .seq_o(in_seq), .start_o(in_start), .term_o(in_term),
    .term_pos_o(in_pos), .k_tail_o(in_ktail), .bad_o(in_bad), .err_o(in_err)
  );

  // column under decision, one stage behind the input
  logic [LANES*CW-1:0] cur_d;
  logic [LANES-1:0]    cur_c, cur_bad, cur_err, cur_ktail;
  logic                cur_idle, cur_seq, cur_start, cur_term;
  logic [PW-1:0]       cur_pos;
  rx_state_e           state_q, state_d;
  logic [LANES*CW-1:0] od, xd_q, term_d;
  logic [LANES-1:0]    oc, xc_q, term_c;
  logic                term_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_d     <= {LANES{K_K}};
      cur_c     <= '1;
      cur_bad   <= '1;
      cur_err   <= '0;
      cur_ktail <= '0;
      cur_idle  <= 1'b1;
      cur_seq   <= 1'b0;
      cur_start <= 1'b0;
      cur_term  <= 1'b0;
      cur_pos   <= '0;
    end else begin
      cur_d     <= rx_data_i;
      cur_c     <= rx_ctrl_i;
      cur_bad   <= in_bad;
      cur_err   <= in_err;
      cur_ktail <= in_ktail;
      cur_idle  <= in_idle;
      cur_seq   <= in_seq;
      cur_start <= in_start;
      cur_term  <= in_term;
      cur_pos   <= in_pos;
    end
  end

  assign term_pass = cur_ktail[cur_pos] & in_idle;

  pcs_rx_term_xlate #(.LANES(LANES), .CW(CW), .PW(PW)) u_term (
    .d_i(cur_d), .bad_i(cur_bad), .pos_i(cur_pos), .pass_i(term_pass),
    .d_o(term_d), .c_o(term_c)
  );

  always_comb begin
    state_d = state_q;
    od      = cur_d;
    oc      = cur_c;
    if (cur_term) begin
      od      = term_d;
      oc      = term_c;
      state_d = ST_RECV;
    end else if (state_q == ST_DATA) begin
      for (int l = 0; l < LANES; l++) begin
        od[l*CW +: CW] = cur_bad[l] ? C_ERR : cur_d[l*CW +: CW];
        oc[l]          = cur_bad[l];
      end
    end else if (cur_start) begin
      state_d = ST_DATA;
    end else if (cur_idle) begin
      od      = IDLE_COL;
      oc      = '1;
      state_d = ST_RECV;
    end else if (cur_seq) begin
      state_d = ST_SEQ;
    end else if (state_q == ST_SEQ) begin
      // errored column right after an ordered set
      od      = ERR_COL;
      oc      = '1;
      state_d = ST_RECV;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        od[l*CW +: CW] = cur_err[l] ? C_ERR : cur_d[l*CW +: CW];
        oc[l]          = cur_c[l] | cur_err[l];
      end
      state_d = ST_RECV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECV;
      xd_q    <= IDLE_COL;
      xc_q    <= '1;
    end else begin
      state_q <= state_d;
      xd_q    <= od;
      xc_q    <= oc;
    end
  end

  assign xg_data_o = xd_q;
  assign xg_ctrl_o = xc_q;

  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_idle && state_q != ST_DATA) |=> (xg_data_o == IDLE_COL && xg_ctrl_o == '1)); // R1
  AST_DATA_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) != ST_DATA) |-> $past(cur_start)); // R2
  AST_SEQ_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_seq && state_q != ST_DATA) |=>
      (xg_ctrl_o == {{(LANES-1){1'b0}}, 1'b1} && xg_data_o[CW-1:0] == C_SEQ)); // R3
  AST_TERM_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_term |=> state_q == ST_RECV); // R4
  AST_TERM_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_term && !in_idle) |=> (xg_data_o == ERR_COL && xg_ctrl_o == '1)); // R5
  AST_ERR_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !cur_term && cur_bad[0]) |=>
      (xg_data_o[CW-1:0] == C_ERR && xg_ctrl_o[0])); // R6
endmodule

// File: tb/pcs_rx_decode_test.sv
module pcs_rx_decode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_d = 32'hBCBCBCBC;
  logic [3:0]  rx_c = 4'hF;
  logic [3:0]  rx_v = 4'h0;
  logic [31:0] xd;
  logic [3:0]  xc;
  int checks = 0;
  int errors = 0;

  // model state: 0 between frames, 1 after sequence, 2 in frame
  int          m_state;
  logic [31:0] m_d, exp_d;
  logic [3:0]  m_c, m_v, exp_c;
  string       exp_req;

  pcs_rx_decode uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_d), .rx_ctrl_i(rx_c), .rx_cv_i(rx_v),
    .xg_data_o(xd), .xg_ctrl_o(xc)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired, actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] ch(logic [31:0] d, int l);
    return d[l*8 +: 8];
  endfunction

  function automatic bit col_idle(logic [31:0] d, logic [3:0] c, logic [3:0] v);
    for (int l = 0; l < 4; l++)
      if (!c[l] || v[l] || !(ch(d, l) == 8'hBC || ch(d, l) == 8'h7C || ch(d, l) == 8'h1C))
        return 0;
    return 1;
  endfunction

  function automatic bit col_lead(logic [31:0] d, logic [3:0] c, logic [3:0] v, logic [7:0] code);
    return c[0] && !v[0] && ch(d, 0) == code && c[3:1] == 3'b000 && v[3:1] == 3'b000;
  endfunction

  task automatic chk(string req, logic [31:0] gd, logic [3:0] gc, logic [31:0] ed, logic [3:0] ec);
    checks++;
    if (gd !== ed || gc !== ec) begin
      errors++;
      $display("FAIL %s actual d=%h c=%b expected d=%h c=%b", req, gd, gc, ed, ec);
    end
  endtask

  // reference of one clock edge: decide the held column using the new one as lookahead
  task automatic model_edge(logic [31:0] nd, logic [3:0] nc, logic [3:0] nv);
    int tp = -1;
    for (int l = 3; l >= 0; l--)
      if (m_c[l] && !m_v[l] && ch(m_d, l) == 8'hFD) tp = l;
    exp_d = m_d;
    exp_c = m_c;
    if (tp >= 0) begin
      bit ok = col_idle(nd, nc, nv);
      for (int l = tp + 1; l < 4; l++)
        if (!(m_c[l] && !m_v[l] && ch(m_d, l) == 8'hBC)) ok = 0;
      for (int l = 0; l < 4; l++) begin
        if (!ok)          begin exp_d[l*8 +: 8] = 8'hFE; exp_c[l] = 1; end
        else if (l < tp)  begin
          exp_c[l] = m_c[l] | m_v[l];
          if (exp_c[l]) exp_d[l*8 +: 8] = 8'hFE;
        end
        else if (l == tp) begin exp_d[l*8 +: 8] = 8'hFD; exp_c[l] = 1; end
        else              begin exp_d[l*8 +: 8] = 8'h07; exp_c[l] = 1; end
      end
      exp_req = ok ? "R4" : "R5";
      m_state = 0;
    end else if (m_state == 2) begin
      for (int l = 0; l < 4; l++) begin
        exp_c[l] = m_c[l] | m_v[l];
        if (exp_c[l]) exp_d[l*8 +: 8] = 8'hFE;
      end
      exp_req = "R6";
    end else if (col_lead(m_d, m_c, m_v, 8'hFB)) begin
      exp_req = "R2";
      m_state = 2;
    end else if (col_idle(m_d, m_c, m_v)) begin
      exp_d = 32'h07070707; exp_c = 4'hF;
      exp_req = "R1";
      m_state = 0;
    end else if (col_lead(m_d, m_c, m_v, 8'h9C)) begin
      exp_req = "R3";
      m_state = 1;
    end else if (m_state == 1) begin
      exp_d = 32'hFEFEFEFE; exp_c = 4'hF;
      exp_req = "R7";
      m_state = 0;
    end else begin
      for (int l = 0; l < 4; l++)
        if (m_v[l] || (m_c[l] && ch(m_d, l) == 8'hFE)) begin
          exp_d[l*8 +: 8] = 8'hFE; exp_c[l] = 1;
        end
      exp_req = "R8";
      m_state = 0;
    end
    m_d = nd; m_c = nc; m_v = nv;
  endtask

  // inputs change at the falling edge; outputs compared at the next falling edge (R9 latency in model)
  task automatic step(logic [31:0] d, logic [3:0] c, logic [3:0] v = 4'h0);
    rx_d = d; rx_c = c; rx_v = v;
    @(posedge clk);
    model_edge(d, c, v);
    @(negedge clk);
    chk(exp_req, xd, xc, exp_d, exp_c);
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) step(32'hBCBCBCBC, 4'hF);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_d = 32'hBCBCBCBC; rx_c = 4'hF; rx_v = 4'h0;
    @(negedge clk);
    chk("R10 in reset", xd, xc, 32'h07070707, 4'hF);
    @(negedge clk);
    rst_n = 1'b1;
    m_state = 0; m_d = 32'hBCBCBCBC; m_c = 4'hF; m_v = 4'h0;
  endtask

  initial begin
    do_reset();
    chk("R10 after release", xd, xc, 32'h07070707, 4'hF);
    // R1: idle mixes
    step(32'h7CBC1CBC, 4'hF); step(32'h1C1C7C7C, 4'hF); idle(2);
    // R3: sequence then idle, repeated sequences
    step(32'h0000019C, 4'h1); idle(1);
    step(32'h0000019C, 4'h1); step(32'h0000019C, 4'h1); idle(2);
    // R7: garbage after sequence
    step(32'h0000019C, 4'h1); step(32'h44332211, 4'h0); idle(2);
    // R4: good frames, terminate in each lane
    step(32'h332211FB, 4'h1); step(32'h77665544, 4'h0); step(32'hBCFD9988, 4'hC); idle(2);
    step(32'h332211FB, 4'h1); step(32'hBCBCBCFD, 4'hF); idle(2);
    step(32'h332211FB, 4'h1); step(32'hFD121110, 4'h8); idle(2);
    step(32'h332211FB, 4'h1); step(32'hBCBCFD10, 4'hE); idle(2);
    // R6: errors inside frame do not drop terminate handling
    step(32'h332211FB, 4'h1); step(32'h55FE5150, 4'h2); step(32'h63626160, 4'h0, 4'h8);
    step(32'hBCFD7170, 4'hC); idle(2);
    // R2: start inside frame flagged as error
    step(32'h332211FB, 4'h1); step(32'h332211FB, 4'h1); step(32'hBCBCBCFD, 4'hF); idle(2);
    // R5: terminate followed by non-idle column, then that column out of frame (R8)
    step(32'h332211FB, 4'h1); step(32'hBCBCFD10, 4'hE); step(32'hA3A2A1A0, 4'h0); idle(2);
    // R5: non-K after terminate
    step(32'h332211FB, 4'h1); step(32'h7CBCFD10, 4'hE); idle(2);
    // R5: terminate then sequence column
    step(32'h332211FB, 4'h1); step(32'hBCBCBCFD, 4'hF); step(32'h0000019C, 4'h1); idle(2);
    // R8: out-of-frame errors and raw data
    step(32'hBCFEBCBC, 4'hF); step(32'h04030201, 4'h0, 4'h4); idle(2);
    // R9: a data column leaves the block two clocks later, not one
    rx_d = 32'hDDCCBBAA; rx_c = 4'h0; rx_v = 4'h0;
    @(posedge clk); model_edge(32'hDDCCBBAA, 4'h0, 4'h0); @(negedge clk);
    chk("R9 one clock", xd, xc, 32'h07070707, 4'hF);
    step(32'hBCBCBCBC, 4'hF);
    chk("R9 two clocks", xd, xc, 32'hDDCCBBAA, 4'h0);
    idle(1);
    // R4: terminate outside a frame
    step(32'hBCBCFD10, 4'hE); idle(2);
    // R10: reset in mid-frame returns to between-frames state
    step(32'h332211FB, 4'h1); step(32'h77665544, 4'h0);
    do_reset();
    chk("R10 mid-frame reset", xd, xc, 32'h07070707, 4'hF);
    step(32'h88776655, 4'h0); step(32'h99887766, 4'h0, 4'h1); idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule